// File: doc/BRIEF.md
# Debug Hart Handshake Mailbox

This block sits between a debug module and the harts that spin in a debug ROM loop. The harts reach it through a simple memory-mapped slave port. A parked hart keeps writing its own ID to a "parked" mailbox word. It polls a one-byte command flag of its own in a flag window, and it writes further mailbox words when it accepts a command, when it leaves debug mode and when a command faults. The debugger side drives short request pulses. One pulse starts a command on one hart and another releases a set of harts. In return it sees a halted bit for each hart, a busy line and a sticky fault flag.

Command dispatch is a three-state machine with the states IDLE, ARMED and RUNNING. Transition ARM (IDLE to ARMED) happens when the debugger asks for a command on an existing hart. It latches that hart as the target and raises its command bit. Transition ACK (ARMED to RUNNING) happens on a write to the accept word, and it drops the command bit. Transition DONE (RUNNING to IDLE) happens when the target hart writes its ID to the parked word again. Transition FAULT (RUNNING to IDLE) happens on a write to the fault word. Release bits are tracked per hart and can be pending on several harts at once. A hart's release bit is cleared when that hart reports it is leaving or parks again.

Bus addresses are byte offsets. Mailbox words sit at 0x100 (parked), 0x104 (accepted), 0x108 (leaving) and 0x10C (fault). Flag bytes sit at 0x400 plus the hart index. The command-target word at 0x300 and the ROM entry at 0x800 belong to other logic and are not decoded here. Reads return their data one cycle after the request.

Top module: `dbg_hart_mailbox`

## Requirements
- R1: A synchronous reset clears every halted bit, every command and release bit, the fault flag, the busy line and the read-valid output.
- R2: A write to offset 0x100 whose data is a hart index below NHARTS sets that hart's halted bit and clears its release bit; data at or above NHARTS changes nothing.
- R3: A read is answered one cycle later with `bus_rvalid` high for exactly that cycle. Reading offset 0x400+h for an existing hart h returns bit 0 = command pending, bit 1 = release pending and all other bits zero. Reading any other offset, including a flag byte of a hart that does not exist, returns zero.
- R4: A command request with an existing hart index while the block is IDLE sets that hart's command bit and raises `cmd_busy`. At most one hart has its command bit set at any time.
- R5: A write to offset 0x104 while ARMED clears the command bit, and `cmd_busy` stays high. `cmd_busy` falls only when the target hart writes its own index to 0x100; writes there from other harts leave it high.
- R6: A release request sets the release bit of every hart whose mask bit is 1, and several harts may hold release bits at once.
- R7: A write to offset 0x108 whose data is a hart index clears that hart's release bit and halted bit and no other hart's. A release request for the same hart in the same cycle wins, and the bit stays set.
- R8: A write to offset 0x10C sets `exc_seen`, which stays set until `dbg_exc_clear`; a fault write in the same cycle as the clear wins. In RUNNING the fault write also returns the machine to IDLE, while in ARMED it leaves the command pending.
- R9: Writes to offsets 0x300, 0x800, the flag window or any other undecoded offset change no state.
- R10: A command request while `cmd_busy` is high is ignored: the pending target and its command bit are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the request |
| bus_wdata | input | DATA_W | Write data (hart index for ID-carrying words) |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_rdata | output | DATA_W | Read data |
| dbg_go_req | input | 1 | Start-command request pulse |
| dbg_go_hart | input | IDX_W | Target hart of the command request |
| dbg_resume_req | input | 1 | Release request pulse |
| dbg_resume_mask | input | NHARTS | Harts to release |
| dbg_exc_clear | input | 1 | Clears the sticky fault flag |
| hart_halted | output | NHARTS | Halted bit of each hart |
| cmd_busy | output | 1 | High from ARM until DONE or FAULT |
| exc_seen | output | 1 | Sticky fault flag |

## Verification
The bench walks one command through every transition. On the way it checks that the target's flag byte shows the command bit only while ARMED, and that a parked write from another hart does not end RUNNING; a design that keyed DONE on any parked write would drop busy early. It issues a command request while busy and checks the first target survives, which a design that re-armed would break. It applies a release set and a leaving write for the same hart in one cycle and a fault write together with the fault clear, where a wrong priority loses the event. It also writes hart indexes past NHARTS, writes to the command-target and entry offsets, and reads flag bytes of absent harts, where a loose decoder would corrupt state or return stale bits.

// File: rtl/dbg_mbx_pkg.sv
package dbg_mbx_pkg;

    // byte offsets decoded by the mailbox
    localparam int unsigned OFS_PARKED  = 32'h100;
    localparam int unsigned OFS_ACCEPT  = 32'h104;
    localparam int unsigned OFS_LEAVING = 32'h108;
    localparam int unsigned OFS_FAULT   = 32'h10C;
    localparam int unsigned OFS_FLAGS   = 32'h400;
    localparam int unsigned FLAG_SPAN   = 32'h400;

    // bit positions inside one hart's flag byte
    localparam int unsigned FLAG_BIT_CMD = 0;
    localparam int unsigned FLAG_BIT_REL = 1;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,
        GS_ARMED   = 2'd1,
        GS_RUNNING = 2'd2
    } go_state_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PARKED  = 3'd1,
        OP_ACCEPT  = 3'd2,
        OP_LEAVING = 3'd3,
        OP_FAULT   = 3'd4,
        OP_READ    = 3'd5
    } bus_op_e;

endpackage

// File: rtl/dbg_mbx_decode.sv
module dbg_mbx_decode
    import dbg_mbx_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_op_e           op,
    output logic [IDX_W-1:0]  wr_id,
    output logic              wr_id_ok,
    output logic              rd_flag_hit,
    output logic [IDX_W-1:0]  rd_idx
);

    logic [31:0] addr_ext;
    logic [31:0] flag_rel;

    assign addr_ext = 32'(bus_addr);
    assign flag_rel = addr_ext - OFS_FLAGS;

    // hart index carried in the write data
    assign wr_id    = bus_wdata[IDX_W-1:0];
    assign wr_id_ok = (bus_wdata < DATA_W'(NHARTS));

    // flag window: only bytes of harts that exist are hits
    assign rd_flag_hit = (addr_ext >= OFS_FLAGS) &&
                         (flag_rel < FLAG_SPAN) &&
                         (flag_rel < 32'(NHARTS));
    assign rd_idx      = flag_rel[IDX_W-1:0];

    always_comb begin
        op = OP_NONE;
        if (bus_valid) begin
            if (!bus_write) begin
                op = OP_READ;
            end else begin
                case (addr_ext)
                    OFS_PARKED:  op = OP_PARKED;
                    OFS_ACCEPT:  op = OP_ACCEPT;
                    OFS_LEAVING: op = OP_LEAVING;
                    OFS_FAULT:   op = OP_FAULT;
                    default:     op = OP_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/dbg_mbx_go_fsm.sv
module dbg_mbx_go_fsm
    import dbg_mbx_pkg::*;
#(
    parameter int NHARTS = 4,
    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_req,
    input  logic [IDX_W-1:0]  go_hart,
    input  bus_op_e           op,
    input  logic [IDX_W-1:0]  wr_id,
    input  logic              wr_id_ok,
    output logic [NHARTS-1:0] go_vec,
    output logic              busy
);

    go_state_e        state_q;
    go_state_e        state_d;
    logic [IDX_W-1:0] tgt_q;
    logic             arm;
    logic             tgt_parked;

    assign arm        = go_req && (32'(go_hart) < 32'(NHARTS));
    assign tgt_parked = (op == OP_PARKED) && wr_id_ok && (wr_id == tgt_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GS_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == GS_IDLE && arm) begin
                tgt_q <= go_hart;
            end
        end
    end

    // transitions ARM, ACK, DONE, FAULT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (arm) state_d = GS_ARMED;
            end
            GS_ARMED: begin
                if (op == OP_ACCEPT) state_d = GS_RUNNING;
            end
            GS_RUNNING: begin
                if (tgt_parked)          state_d = GS_IDLE;
                else if (op == OP_FAULT) state_d = GS_IDLE;
            end
            default: state_d = GS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != GS_IDLE);
    end

    for (genvar h = 0; h < NHARTS; h++) begin : g_go
        assign go_vec[h] = (state_q == GS_ARMED) && (tgt_q == IDX_W'(h));
    end

endmodule

// File: rtl/dbg_mbx_hart_state.sv
module dbg_mbx_hart_state
    import dbg_mbx_pkg::*;
#(
    parameter int NHARTS = 4,
    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_e           op,
    input  logic [IDX_W-1:0]  wr_id,
    input  logic              wr_id_ok,
    input  logic              rel_req,
    input  logic [NHARTS-1:0] rel_mask,
    input  logic              exc_clear,
    output logic [NHARTS-1:0] halted,
    output logic [NHARTS-1:0] rel_vec,
    output logic              exc_flag
);

    for (genvar h = 0; h < NHARTS; h++) begin : g_hart
        logic hit;
        logic halted_q;
        logic rel_q;

        assign hit = wr_id_ok && (wr_id == IDX_W'(h));

        always_ff @(posedge clk) begin
            if (rst) begin
                halted_q <= 1'b0;
                rel_q    <= 1'b0;
            end else begin
                if (op == OP_PARKED && hit)       halted_q <= 1'b1;
                else if (op == OP_LEAVING && hit) halted_q <= 1'b0;

                // a new release request outranks an acknowledge
                if (rel_req && rel_mask[h])       rel_q <= 1'b1;
                else if ((op == OP_PARKED || op == OP_LEAVING) && hit)
                                                  rel_q <= 1'b0;
            end
        end

        assign halted[h]  = halted_q;
        assign rel_vec[h] = rel_q;
    end

    always_ff @(posedge clk) begin
        if (rst)                  exc_flag <= 1'b0;
        else if (op == OP_FAULT)  exc_flag <= 1'b1;
        else if (exc_clear)       exc_flag <= 1'b0;
    end

endmodule

// File: rtl/dbg_mbx_rdport.sv
module dbg_mbx_rdport
    import dbg_mbx_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_e           op,
    input  logic              rd_flag_hit,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [NHARTS-1:0] go_vec,
    input  logic [NHARTS-1:0] rel_vec,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    logic [7:0] flag_byte;

    always_comb begin
        flag_byte = '0;
        if (rd_flag_hit) begin
            flag_byte[FLAG_BIT_CMD] = go_vec[rd_idx];
            flag_byte[FLAG_BIT_REL] = rel_vec[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= (op == OP_READ);
            rdata  <= (op == OP_READ) ? DATA_W'(flag_byte) : '0;
        end
    end

endmodule

// File: rtl/dbg_hart_mailbox.sv
module dbg_hart_mailbox
    import dbg_mbx_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_go_req,
    input  logic [IDX_W-1:0]  dbg_go_hart,
    input  logic              dbg_resume_req,
    input  logic [NHARTS-1:0] dbg_resume_mask,
    input  logic              dbg_exc_clear,
    output logic [NHARTS-1:0] hart_halted,
    output logic              cmd_busy,
    output logic              exc_seen
);

    bus_op_e           op;
    logic [IDX_W-1:0]  wr_id;
    logic              wr_id_ok;
    logic              rd_flag_hit;
    logic [IDX_W-1:0]  rd_idx;
    logic [NHARTS-1:0] go_flags;
    logic [NHARTS-1:0] rel_flags;

    dbg_mbx_decode #(
        .NHARTS(NHARTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_decode (
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .op          (op),
        .wr_id       (wr_id),
        .wr_id_ok    (wr_id_ok),
        .rd_flag_hit (rd_flag_hit),
        .rd_idx      (rd_idx)
    );

    dbg_mbx_go_fsm #(
        .NHARTS(NHARTS)
    ) u_go_fsm (
        .clk      (clk),
        .rst      (rst),
        .go_req   (dbg_go_req),
        .go_hart  (dbg_go_hart),
        .op       (op),
        .wr_id    (wr_id),
        .wr_id_ok (wr_id_ok),
        .go_vec   (go_flags),
        .busy     (cmd_busy)
    );

    dbg_mbx_hart_state #(
        .NHARTS(NHARTS)
    ) u_hart_state (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .wr_id     (wr_id),
        .wr_id_ok  (wr_id_ok),
        .rel_req   (dbg_resume_req),
        .rel_mask  (dbg_resume_mask),
        .exc_clear (dbg_exc_clear),
        .halted    (hart_halted),
        .rel_vec   (rel_flags),
        .exc_flag  (exc_seen)
    );

    dbg_mbx_rdport #(
        .NHARTS(NHARTS), .DATA_W(DATA_W)
    ) u_rdport (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .rd_flag_hit (rd_flag_hit),
        .rd_idx      (rd_idx),
        .go_vec      (go_flags),
        .rel_vec     (rel_flags),
        .rvalid      (bus_rvalid),
        .rdata       (bus_rdata)
    );

endmodule

// File: rtl/dbg_mbx_chk.sv
module dbg_mbx_chk
    import dbg_mbx_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    localparam int IDX_W = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic [NHARTS-1:0] hart_halted,
    input logic              cmd_busy,
    input logic              exc_seen,
    input logic              dbg_exc_clear,
    input logic [NHARTS-1:0] go_flags
);

    logic wr_parked, wr_accept, wr_leaving, wr_fault, rd_req, id_ok;

    assign wr_parked  = bus_valid && bus_write && (32'(bus_addr) == OFS_PARKED);
    assign wr_accept  = bus_valid && bus_write && (32'(bus_addr) == OFS_ACCEPT);
    assign wr_leaving = bus_valid && bus_write && (32'(bus_addr) == OFS_LEAVING);
    assign wr_fault   = bus_valid && bus_write && (32'(bus_addr) == OFS_FAULT);
    assign rd_req     = bus_valid && !bus_write;
    assign id_ok      = (bus_wdata < DATA_W'(NHARTS));

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (hart_halted == '0 && !cmd_busy && !exc_seen && !bus_rvalid)); // R1

    AST_PARK_SETS_HALTED: assert property (@(posedge clk) disable iff (rst)
        (wr_parked && id_ok) |=> hart_halted[$past(bus_wdata[IDX_W-1:0])]); // R2

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> bus_rvalid); // R3

    AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !bus_rvalid); // R3

    AST_SINGLE_GO: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_flags)); // R4

    AST_GO_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (go_flags != '0) |-> cmd_busy); // R4

    AST_ACCEPT_CLEARS_GO: assert property (@(posedge clk) disable iff (rst)
        (wr_accept && cmd_busy) |=> (go_flags == '0 && cmd_busy)); // R5

    AST_LEAVING_CLEARS_HALTED: assert property (@(posedge clk) disable iff (rst)
        (wr_leaving && id_ok) |=> !hart_halted[$past(bus_wdata[IDX_W-1:0])]); // R7

    AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wr_fault |=> exc_seen); // R8

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (exc_seen && !dbg_exc_clear) |=> exc_seen); // R8

    AST_GO_HELD: assert property (@(posedge clk) disable iff (rst)
        (go_flags != '0 && !wr_accept) |=> (go_flags == $past(go_flags))); // R10

endmodule

bind dbg_hart_mailbox dbg_mbx_chk #(
    .NHARTS(NHARTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_valid     (bus_valid),
    .bus_write     (bus_write),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rvalid    (bus_rvalid),
    .hart_halted   (hart_halted),
    .cmd_busy      (cmd_busy),
    .exc_seen      (exc_seen),
    .dbg_exc_clear (dbg_exc_clear),
    .go_flags      (go_flags)
);

// File: tb/dbg_hart_mailbox_tb_top.sv
module dbg_hart_mailbox_tb_top;

    localparam int NH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic        dbg_go_req = 1'b0;
    logic [1:0]  dbg_go_hart = '0;
    logic        dbg_resume_req = 1'b0;
    logic [3:0]  dbg_resume_mask = '0;
    logic        dbg_exc_clear = 1'b0;
    logic [3:0]  hart_halted;
    logic        cmd_busy;
    logic        exc_seen;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dbg_hart_mailbox #(.NHARTS(NH), .ADDR_W(12), .DATA_W(32)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .bus_valid       (bus_valid),
        .bus_write       (bus_write),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rvalid      (bus_rvalid),
        .bus_rdata       (bus_rdata),
        .dbg_go_req      (dbg_go_req),
        .dbg_go_hart     (dbg_go_hart),
        .dbg_resume_req  (dbg_resume_req),
        .dbg_resume_mask (dbg_resume_mask),
        .dbg_exc_clear   (dbg_exc_clear),
        .hart_halted     (hart_halted),
        .cmd_busy        (cmd_busy),
        .exc_seen        (exc_seen)
    );

    localparam logic [1:0] KW = 2'd0;  // bus write
    localparam logic [1:0] KR = 2'd1;  // bus read
    localparam logic [1:0] KG = 2'd2;  // command request, data = hart
    localparam logic [1:0] KM = 2'd3;  // release request, data = mask

    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  exp_rd;
        logic [3:0]  exp_halted;
        logic        exp_busy;
        logic        exp_exc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{KW, 12'h100, 32'd2, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd2},  // R2 park hart 2
        '{KW, 12'h100, 32'd0, 8'h00, 4'b0101, 1'b0, 1'b0, 4'd2},  // R2 park hart 0
        '{KW, 12'h100, 32'd7, 8'h00, 4'b0101, 1'b0, 1'b0, 4'd2},  // R2 bad index
        '{KG, 12'h000, 32'd2, 8'h00, 4'b0101, 1'b1, 1'b0, 4'd4},  // R4 arm hart 2
        '{KR, 12'h402, 32'd0, 8'h01, 4'b0101, 1'b1, 1'b0, 4'd3},  // R3 cmd bit
        '{KG, 12'h000, 32'd0, 8'h00, 4'b0101, 1'b1, 1'b0, 4'd10}, // R10 while busy
        '{KR, 12'h400, 32'd0, 8'h00, 4'b0101, 1'b1, 1'b0, 4'd10}, // R10 no retarget
        '{KW, 12'h104, 32'd0, 8'h00, 4'b0101, 1'b1, 1'b0, 4'd5},  // R5 accept
        '{KR, 12'h402, 32'd0, 8'h00, 4'b0101, 1'b1, 1'b0, 4'd5},  // R5 cmd cleared
        '{KW, 12'h100, 32'd0, 8'h00, 4'b0101, 1'b1, 1'b0, 4'd5},  // R5 other hart parks
        '{KW, 12'h100, 32'd2, 8'h00, 4'b0101, 1'b0, 1'b0, 4'd5},  // R5 target parks
        '{KM, 12'h000, 32'h5, 8'h00, 4'b0101, 1'b0, 1'b0, 4'd6},  // R6 release 0,2
        '{KR, 12'h400, 32'd0, 8'h02, 4'b0101, 1'b0, 1'b0, 4'd6},
        '{KR, 12'h402, 32'd0, 8'h02, 4'b0101, 1'b0, 1'b0, 4'd6},
        '{KR, 12'h401, 32'd0, 8'h00, 4'b0101, 1'b0, 1'b0, 4'd6},
        '{KW, 12'h108, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd7},  // R7 hart 0 leaves
        '{KR, 12'h400, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd7},
        '{KR, 12'h402, 32'd0, 8'h02, 4'b0100, 1'b0, 1'b0, 4'd7},
        '{KW, 12'h100, 32'd2, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd2},  // R2 park drops release
        '{KR, 12'h402, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd2},
        '{KR, 12'h404, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd3},  // R3 absent hart
        '{KR, 12'h100, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd3},  // R3 non-flag read
        '{KW, 12'h300, 32'd2, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd9},  // R9
        '{KW, 12'h800, 32'd2, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd9},  // R9
        '{KW, 12'h401, 32'd3, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd9},  // R9
        '{KR, 12'h401, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b0, 4'd9},
        '{KG, 12'h000, 32'd1, 8'h00, 4'b0100, 1'b1, 1'b0, 4'd8},  // R8 arm hart 1
        '{KW, 12'h104, 32'd0, 8'h00, 4'b0100, 1'b1, 1'b0, 4'd8},
        '{KW, 12'h10C, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b1, 4'd8},  // R8 fault ends RUNNING
        '{KR, 12'h401, 32'd0, 8'h00, 4'b0100, 1'b0, 1'b1, 4'd8}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock: drive at the falling edge, sample just after the rising edge
    task automatic step(input logic bv, input logic bw, input logic [11:0] a,
                        input logic [31:0] d, input logic gr, input logic [1:0] gh,
                        input logic rr, input logic [3:0] rm, input logic ec);
        @(negedge clk);
        bus_valid = bv; bus_write = bw; bus_addr = a; bus_wdata = d;
        dbg_go_req = gr; dbg_go_hart = gh;
        dbg_resume_req = rr; dbg_resume_mask = rm; dbg_exc_clear = ec;
        @(posedge clk);
        #1;
        @(negedge clk);
        bus_valid = 1'b0; dbg_go_req = 1'b0; dbg_resume_req = 1'b0; dbg_exc_clear = 1'b0;
    endtask

    // read outputs are observed one cycle after the request, away from the edge
    task automatic rd(input string req, input logic [11:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        #1;
        chk(req, "rvalid", 32'(bus_rvalid), 32'd1);
        chk(req, "rdata", bus_rdata, 32'(exp));
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1", "halted", 32'(hart_halted), 32'd0);
        chk("R1", "busy", 32'(cmd_busy), 32'd0);
        chk("R1", "exc", 32'(exc_seen), 32'd0);
        chk("R1", "rvalid", 32'(bus_rvalid), 32'd0);

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            vec_t v;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            @(negedge clk);
            bus_valid = (v.kind == KW) || (v.kind == KR);
            bus_write = (v.kind == KW);
            bus_addr = v.addr;
            bus_wdata = v.data;
            dbg_go_req = (v.kind == KG);
            dbg_go_hart = v.data[1:0];
            dbg_resume_req = (v.kind == KM);
            dbg_resume_mask = v.data[3:0];
            @(posedge clk);
            #1;
            chk(tag, "halted", 32'(hart_halted), 32'(v.exp_halted));
            chk(tag, "busy", 32'(cmd_busy), 32'(v.exp_busy));
            chk(tag, "exc", 32'(exc_seen), 32'(v.exp_exc));
            chk(tag, "rvalid R3", 32'(bus_rvalid), 32'(v.kind == KR));
            if (v.kind == KR) chk(tag, "rdata", bus_rdata, 32'(v.exp_rd));
            @(negedge clk);
            bus_valid = 1'b0; dbg_go_req = 1'b0; dbg_resume_req = 1'b0;
        end

        // R8 clear, then fault write together with clear: set wins
        step(1'b0, 1'b0, 12'h000, 32'd0, 1'b0, 2'd0, 1'b0, 4'h0, 1'b1);
        chk("R8", "exc cleared", 32'(exc_seen), 32'd0);
        step(1'b1, 1'b1, 12'h10C, 32'd0, 1'b0, 2'd0, 1'b0, 4'h0, 1'b1);
        chk("R8", "fault beats clear", 32'(exc_seen), 32'd1);
        chk("R8", "idle fault no busy", 32'(cmd_busy), 32'd0);
        step(1'b0, 1'b0, 12'h000, 32'd0, 1'b0, 2'd0, 1'b0, 4'h0, 1'b1);

        // R7 release set and leaving write for hart 1 in the same cycle
        step(1'b1, 1'b1, 12'h108, 32'd1, 1'b0, 2'd0, 1'b1, 4'b0010, 1'b0);
        rd("R7", 12'h401, 8'h02);
        step(1'b1, 1'b1, 12'h100, 32'd1, 1'b0, 2'd0, 1'b0, 4'h0, 1'b0);
        chk("R2", "halted", 32'(hart_halted), 32'b0110);
        rd("R2", 12'h401, 8'h00);

        // R8 fault while ARMED keeps the command pending
        step(1'b0, 1'b0, 12'h000, 32'd0, 1'b1, 2'd3, 1'b0, 4'h0, 1'b0);
        step(1'b1, 1'b1, 12'h10C, 32'd0, 1'b0, 2'd0, 1'b0, 4'h0, 1'b0);
        chk("R8", "exc in armed", 32'(exc_seen), 32'd1);
        chk("R8", "busy in armed", 32'(cmd_busy), 32'd1);
        rd("R8", 12'h403, 8'h01);
        step(1'b1, 1'b1, 12'h104, 32'd0, 1'b0, 2'd0, 1'b0, 4'h0, 1'b0);
        rd("R5", 12'h403, 8'h00);
        step(1'b1, 1'b1, 12'h100, 32'd3, 1'b0, 2'd0, 1'b0, 4'h0, 1'b0);
        chk("R5", "done busy", 32'(cmd_busy), 32'd0);
        chk("R2", "halted", 32'(hart_halted), 32'b1110);

        // R1 reset in the middle of activity
        step(1'b0, 1'b0, 12'h000, 32'd0, 1'b1, 2'd0, 1'b1, 4'b1111, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h400;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        bus_valid = 1'b0;
        #1;
        chk("R1", "halted", 32'(hart_halted), 32'd0);
        chk("R1", "busy", 32'(cmd_busy), 32'd0);
        chk("R1", "exc", 32'(exc_seen), 32'd0);
        chk("R1", "rvalid", 32'(bus_rvalid), 32'd0);
        rd("R1", 12'h400, 8'h00);
        rd("R1", 12'h403, 8'h00);

        finish_run();
    end

endmodule